// File: doc/BRIEF.md
# Programmable Parallel I/O Port

A bus-attached parallel port that gives a processor three 8-bit ports, called A, B and C, and one configuration register. The processor accesses them through an active-low chip select, separate active-low read and write strobes, and a 2-bit address. Writes are taken on the rising clock edge while the write strobe is low. Reads are combinational. The data bus is split into an input, an output and an output enable, and the enable is high only during a valid read of a port.

A configuration write sets the direction of port A, of port B, and of each half of port C on its own. Each port keeps an output latch. The latch drives the pins whenever the port is an output. Only simple input/output operation is built. The configuration word also holds a 2-bit mode field for port A. When that field is nonzero, the upper half of port C is set aside for handshake lines: the block then neither drives those pins nor returns them on a read.

Top module: `ppio_port`

## Requirements
- R1: While `rst` is high, and after it is released, every port is an input, all output latches hold zero, and the stored configuration (directions and port A mode) is zero.
- R2: A read with address 0 returns port A, address 1 returns port B, and address 2 returns port C.
- R3: `data_oe` is 1 only when `cs_n`=0, `rd_n`=0, `wr_n`=1 and the address is not 3. It is 0 when `cs_n`=1, when both strobes are high, and for address 3. `data_out` is 0 whenever `data_oe` is 0.
- R4: A write to address 3 updates the configuration only if data bit 7 is 1. A write with bit 7 clear changes nothing.
- R5: In an accepted configuration word, bit 4 sets the direction of port A, bit 1 sets port B, bit 3 sets the upper half of port C, and bit 0 sets the lower half. A value of 1 means input. An output port asserts its enable (`pa_oe`, `pb_oe`, or the matching `pc_oe` bits).
- R6: The two halves of port C each follow their own direction bit. `pc_oe[7:4]` and `pc_oe[3:0]` can differ.
- R7: A write to address 0, 1 or 2 loads that port's output latch whatever its direction. The latch always appears on `pa_out`/`pb_out`/`pc_out`, and it reaches the pins only when the port is an output.
- R8: A read of a port, or of a port C half, set as output returns the latch. One set as input returns the pins.
- R9: Bits 6:5 of the configuration word form the port A mode. While the stored mode is nonzero, `pc_oe[7:4]` is 0 and a port C read returns 0 in bits 7:4. The lower half of port C keeps working normally.
- R10: With `cs_n`=0 and both strobes low at once, no register is written and the data bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 0=A, 1=B, 2=C, 3=configuration |
| data_in | input | 8 | Write data from the processor |
| data_out | output | 8 | Read data to the processor |
| data_oe | output | 1 | Read data bus drive enable |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A pin drive enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B pin drive enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-pin drive enable |

## Verification
The assertions check on every cycle that the bus is quiet when the chip is not selected or no read strobe is active. They also check that reset leaves all pins undriven and the latches cleared, that a configuration word with bit 7 clear leaves the enables unchanged, that a port A write lands in its latch, that the reserved upper half of port C is never driven, and that a double strobe writes nothing. Only the bench's scenarios can show the read-data path. It sweeps every combination of the four direction bits with the reservation both on and off, and uses several latch and pin patterns to prove the address decode and the latch-versus-pin selection on reads.

// File: rtl/ppio_port.sv
module ppio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic [1:0]   addr,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] data_out,
  output logic         data_oe,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic         pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic         pb_oe,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe
);
  localparam int H = W / 2;

  logic         wr_en, rd_en;
  logic         drv_a, drv_b, drv_cu, drv_cl;
  logic [1:0]   mode_a;
  logic [W-1:0] lat_a, lat_b, lat_c;
  logic         c_hi_res;
  logic [H-1:0] rd_cu, rd_cl;

  assign wr_en = !cs_n && !wr_n && rd_n;
  assign rd_en = !cs_n && !rd_n && wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_a  <= 1'b0;
      drv_b  <= 1'b0;
      drv_cu <= 1'b0;
      drv_cl <= 1'b0;
      mode_a <= '0;
      lat_a  <= '0;
      lat_b  <= '0;
      lat_c  <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: lat_a <= data_in;
        2'd1: lat_b <= data_in;
        2'd2: lat_c <= data_in;
        default: if (data_in[7]) begin
          mode_a <= data_in[6:5];
          drv_a  <= !data_in[4];
          drv_cu <= !data_in[3];
          drv_b  <= !data_in[1];
          drv_cl <= !data_in[0];
        end
      endcase
    end
  end

  assign c_hi_res = (mode_a != 2'd0);

  assign pa_out = lat_a;
  assign pb_out = lat_b;
  assign pc_out = lat_c;
  assign pa_oe  = drv_a;
  assign pb_oe  = drv_b;
  assign pc_oe  = {{H{drv_cu && !c_hi_res}}, {H{drv_cl}}};

  assign rd_cu = c_hi_res ? '0 : (drv_cu ? lat_c[W-1:H] : pc_in[W-1:H]);
  assign rd_cl = drv_cl ? lat_c[H-1:0] : pc_in[H-1:0];

  assign data_oe = rd_en && (addr != 2'd3);

  always_comb begin
    data_out = '0;
    if (data_oe) begin
      case (addr)
        2'd0:    data_out = drv_a ? lat_a : pa_in;
        2'd1:    data_out = drv_b ? lat_b : pb_in;
        default: data_out = {rd_cu, rd_cl};
      endcase
    end
  end
endmodule

module ppio_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cs_n,
  input logic         rd_n,
  input logic         wr_n,
  input logic [1:0]   addr,
  input logic [W-1:0] data_in,
  input logic         data_oe,
  input logic [W-1:0] pa_out,
  input logic         pa_oe,
  input logic         pb_oe,
  input logic [W-1:0] pc_out,
  input logic [W-1:0] pc_oe,
  input logic [1:0]   mode_a
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!pa_oe && !pb_oe && pc_oe == '0 && pa_out == '0 && pc_out == '0));

  assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !data_oe);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_n && wr_n) |-> !data_oe);

  assert_cfg_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n && rd_n && addr == 2'd3 && !data_in[7])
      |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  assert_latch_load_R7: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n && rd_n && addr == 2'd0) |=> (pa_out == $past(data_in)));

  assert_reserved_hi_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_a != 2'd0) |-> (pc_oe[W-1:W/2] == '0));

  assert_double_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && !wr_n) |=> ($stable(pa_out) && $stable(pc_out) && $stable(pa_oe)));
endmodule

bind ppio_port ppio_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .addr(addr), .data_in(data_in), .data_oe(data_oe),
  .pa_out(pa_out), .pa_oe(pa_oe), .pb_oe(pb_oe),
  .pc_out(pc_out), .pc_oe(pc_oe), .mode_a(mode_a)
);

// File: tb/sim_ppio_port.sv
module sim_ppio_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] data_in = '0;
  logic [7:0] data_out;
  logic       data_oe;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] pa_out, pb_out, pc_out, pc_oe;
  logic       pa_oe, pb_oe;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ppio_port u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1; addr = a; data_in = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, input string req,
                        input logic exp_oe, input logic [7:0] exp_d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; addr = a;
    #1;
    chk({req, " oe"}, data_oe, exp_oe);
    chk({req, " data"}, data_out, exp_d);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] la, lb, lc, cw;
    logic da, db, dcu, dcl, res;
    repeat (3) @(negedge clk);
    chk("R1 pa_oe", pa_oe, 0);
    chk("R1 pb_oe", pb_oe, 0);
    chk("R1 pc_oe", pc_oe, 0);
    chk("R1 latches", {pa_out, pb_out, pc_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {pa_oe, pb_oe, pc_oe}, 0);
    pa_in = 8'h3C;
    bus_rd(2'd0, "R1 R8 read input A", 1, 8'h3C);

    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1; addr = 2'd0; #1;
    chk("R3 both strobes high", {data_oe, data_out}, 0);
    cs_n = 1'b1; rd_n = 1'b0; #1;
    chk("R3 deselected", {data_oe, data_out}, 0);
    rd_n = 1'b1;
    bus_rd(2'd3, "R3 addr3 read", 0, 8'h00);

    for (int cfg = 0; cfg < 32; cfg++) begin
      da = cfg[0]; db = cfg[1]; dcu = cfg[2]; dcl = cfg[3]; res = cfg[4];
      cw = 8'h80 | ({7'd0, res} << 5) | ({7'd0, da} << 4) | ({7'd0, dcu} << 3)
         | ({7'd0, db} << 1) | {7'd0, dcl};
      bus_wr(2'd3, cw);
      bus_wr(2'd3, ~cw & 8'h7F);
      @(negedge clk);
      chk("R5 pa_oe", pa_oe, !da);
      chk("R4 R5 pb_oe", pb_oe, !db);
      chk("R6 R9 pc_oe", pc_oe, {{4{!dcu && !res}}, {4{!dcl}}});
      for (int p = 0; p < 3; p++) begin
        la = 8'(cfg * 7 + p * 37 + 1);
        lb = 8'(cfg * 13 + p * 59 + 2);
        lc = 8'(cfg * 29 + p * 83 + 3);
        pa_in = ~la; pb_in = 8'(lb + 8'h55); pc_in = 8'(lc ^ 8'hA6);
        bus_wr(2'd0, la);
        bus_wr(2'd1, lb);
        bus_wr(2'd2, lc);
        @(negedge clk);
        chk("R7 latches", {pa_out, pb_out, pc_out}, {la, lb, lc});
        bus_rd(2'd0, "R2 R8 port A", 1, da ? pa_in : la);
        bus_rd(2'd1, "R2 R8 port B", 1, db ? pb_in : lb);
        bus_rd(2'd2, "R2 R6 R9 port C", 1,
               {res ? 4'h0 : (dcu ? pc_in[7:4] : lc[7:4]),
                dcl ? pc_in[3:0] : lc[3:0]});
      end
    end

    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h11);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = 2'd0; data_in = 8'hEE; #1;
    chk("R10 no drive", {data_oe, data_out}, 0);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    chk("R10 no write", pa_out, 8'h11);
    bus_rd(2'd0, "R10 readback", 1, 8'h11);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 mid reset oe", {pa_oe, pb_oe, pc_oe}, 0);
    chk("R1 mid reset latch", {pa_out, pb_out, pc_out}, 0);
    bus_wr(2'd3, 8'h80);
    @(negedge clk);
    chk("R1 R5 latch zero when driven", {pa_oe, pa_out}, {1'b1, 8'h00});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule